// File: doc/BRIEF.md
# Double-Buffered Tile Destination Register

This block is a destination register file made of tile slots and shared by two agents. A compute agent writes results into the half it currently owns. At the same time a drain agent reads out the other half. Both agents address slots by an index relative to their own half. A commit from the compute side hands its half over to the drain side, and the compute side moves to the opposite half. A release from the drain side gives its half back. Each tile is reduced to a single data word per slot.

A width-mode input selects full capacity (16-bit data) or half capacity (32-bit data). In half-capacity mode the total slot count and the usable slots per half are both halved. An index at or beyond the half size is not blocked. The access wraps into the neighbouring half, so the corruption stays visible. A one-cycle error pulse reports that such an access took place.

Top module: `dbt_dest_regfile`

## Requirements
- R1: After reset the compute side owns half 0 (`math_half`=0). The drain side owns nothing (`drain_owns`=0, `drain_half`=1). `busy`=0, and every slot reads as zero.
- R2: A read issued with `rd_en` returns the slot word on `rd_data` with `rd_valid`=1 on the next cycle. The value is the word last written to that physical slot.
- R3: With total slot count T (T=SLOTS in 16-bit mode) and half size H=T/2, a relative index i used on half h reaches physical slot (h*H + i) mod T. Writes use `math_half` and reads use `drain_half`.
- R4: A `math_commit` while the drain side owns nothing is accepted in that cycle. On the next cycle `drain_half` equals the old `math_half`, `drain_owns`=1, and `math_half` is inverted.
- R5: A `drain_release` while the drain side owns a half clears `drain_owns` on the next cycle. A release while nothing is owned has no effect.
- R6: A `math_commit` while the drain side owns a half is held, and `busy`=1 from the next cycle on. The held commit is accepted in the cycle of the next `drain_release`, with the R4 effects, and `busy` returns to 0 on the cycle after.
- R7: With `mode32`=1 the total slot count is SLOTS/2 and the half size is SLOTS/4. The mapping of R3 applies with those values.
- R8: `err` is 1 on the cycle after any access (write with `wr_en` or read with `rd_en`) whose relative index is at least the half size, and 0 otherwise. The access is still carried out at the R3 address.
- R9: A write and a read in the same cycle both complete. A read of the slot being written in that cycle returns the word held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode32 | input | 1 | 1 = 32-bit data mode (half capacity) |
| wr_en | input | 1 | Compute-side write strobe |
| wr_idx | input | IDXW | Write index relative to `math_half` |
| wr_data | input | DW | Word to write |
| math_commit | input | 1 | Compute side hands over its half |
| rd_en | input | 1 | Drain-side read strobe |
| rd_idx | input | IDXW | Read index relative to `drain_half` |
| drain_release | input | 1 | Drain side returns its half |
| rd_data | output | DW | Read word, one cycle after `rd_en` |
| rd_valid | output | 1 | `rd_data` carries a fresh read |
| math_half | output | 1 | Half owned by the compute side |
| drain_owns | output | 1 | Drain side currently owns a half |
| drain_half | output | 1 | Half assigned to the drain side |
| busy | output | 1 | A commit is held waiting for release |
| err | output | 1 | Out-of-range access in the previous cycle |

## Verification
The bench uses the default SLOTS=16 and DW=16. Each mode gets its own random run, and the design is reset between the two runs. In 16-bit mode, full-range 4-bit indices reach every aliasing offset, including index 8 from half 0 landing in slot 0 of half 1. In 32-bit mode, indices of 4 and up wrap within the 8-slot space. Random commit and release strobes cover accepted commits, held commits, release-with-commit in the same cycle, and stray releases.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  typedef enum logic {
    WM_16 = 1'b0,
    WM_32 = 1'b1
  } width_mode_e;
endpackage

// File: rtl/dbt_map.sv
module dbt_map #(
  parameter int SLOTS = 16,
  localparam int IDXW = $clog2(SLOTS)
) (
  input  logic            half_sel,
  input  logic [IDXW-1:0] idx,
  input  logic            mode32,
  output logic [IDXW-1:0] phys,
  output logic            oor
);
  import dbt_pkg::*;
  localparam int HALF16 = SLOTS / 2;
  localparam int HALF32 = SLOTS / 4;

  logic [IDXW:0] base;
  logic [IDXW:0] sum;
  width_mode_e   wm;

  always_comb begin
    wm   = width_mode_e'(mode32);
    base = '0;
    if (half_sel) base = (wm == WM_32) ? (IDXW+1)'(HALF32) : (IDXW+1)'(HALF16);
    sum  = base + {1'b0, idx};
    if (wm == WM_32) begin
      phys = {1'b0, sum[IDXW-2:0]};
      oor  = ({1'b0, idx} >= (IDXW+1)'(HALF32));
    end else begin
      phys = sum[IDXW-1:0];
      oor  = ({1'b0, idx} >= (IDXW+1)'(HALF16));
    end
  end
endmodule

// File: rtl/dbt_owner.sv
module dbt_owner (
  input  logic clk,
  input  logic rst,
  input  logic commit,
  input  logic release_req,
  output logic math_half,
  output logic drain_owns,
  output logic drain_half,
  output logic busy
);
  logic rel_ok;
  logic accept;

  always_comb begin
    rel_ok = release_req && drain_owns;
    accept = (commit || busy) && (!drain_owns || rel_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      math_half  <= 1'b0;
      drain_owns <= 1'b0;
      drain_half <= 1'b1;
      busy       <= 1'b0;
    end else begin
      if (accept) begin
        drain_half <= math_half;
        math_half  <= ~math_half;
        drain_owns <= 1'b1;
        busy       <= 1'b0;
      end else begin
        if (rel_ok) drain_owns <= 1'b0;
        if (commit) busy <= 1'b1;
      end
    end
  end

  p_disjoint_r5: assert property (@(posedge clk) disable iff (rst)
    drain_owns |-> (drain_half != math_half));
  p_accept_r4: assert property (@(posedge clk) disable iff (rst)
    (commit && !drain_owns) |=> (drain_owns && drain_half == $past(math_half)));
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !release_req) |=> busy);
  p_free_r5: assert property (@(posedge clk) disable iff (rst)
    (release_req && drain_owns && !busy && !commit) |=> !drain_owns);
endmodule

// File: rtl/dbt_store.sv
module dbt_store #(
  parameter int SLOTS = 16,
  parameter int DW    = 16,
  localparam int IDXW = $clog2(SLOTS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IDXW-1:0] wa,
  input  logic [DW-1:0]   wd,
  input  logic            re,
  input  logic [IDXW-1:0] ra,
  output logic [DW-1:0]   rd,
  output logic            rv
);
  logic [DW-1:0]    mem [SLOTS];
  logic [SLOTS-1:0] filled;
  logic [DW-1:0]    q;
  logic             q_filled;

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) q <= mem[ra];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filled   <= '0;
      q_filled <= 1'b0;
      rv       <= 1'b0;
    end else begin
      if (we) filled[wa] <= 1'b1;
      if (re) q_filled <= filled[ra];
      rv <= re;
    end
  end

  assign rd = q_filled ? q : '0;

  p_rd_valid_r2: assert property (@(posedge clk) disable iff (rst)
    re |=> rv);
  p_rd_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !re |=> !rv);
endmodule

// File: rtl/dbt_dest_regfile.sv
module dbt_dest_regfile #(
  parameter int SLOTS = 16,
  parameter int DW    = 16,
  localparam int IDXW = $clog2(SLOTS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode32,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic            math_commit,
  input  logic            rd_en,
  input  logic [IDXW-1:0] rd_idx,
  input  logic            drain_release,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid,
  output logic            math_half,
  output logic            drain_owns,
  output logic            drain_half,
  output logic            busy,
  output logic            err
);
  logic [IDXW-1:0] wr_phys, rd_phys;
  logic            wr_oor, rd_oor;

  dbt_owner i_owner (
    .clk(clk), .rst(rst), .commit(math_commit), .release_req(drain_release),
    .math_half(math_half), .drain_owns(drain_owns), .drain_half(drain_half),
    .busy(busy)
  );

  dbt_map #(.SLOTS(SLOTS)) i_wmap (
    .half_sel(math_half), .idx(wr_idx), .mode32(mode32),
    .phys(wr_phys), .oor(wr_oor)
  );

  dbt_map #(.SLOTS(SLOTS)) i_rmap (
    .half_sel(drain_half), .idx(rd_idx), .mode32(mode32),
    .phys(rd_phys), .oor(rd_oor)
  );

  dbt_store #(.SLOTS(SLOTS), .DW(DW)) i_store (
    .clk(clk), .rst(rst), .we(wr_en), .wa(wr_phys), .wd(wr_data),
    .re(rd_en), .ra(rd_phys), .rd(rd_data), .rv(rd_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= (wr_en && wr_oor) || (rd_en && rd_oor);
  end

  p_err_wr_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_oor) |=> err);
  p_err_rd_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_oor) |=> err);
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !rd_en) |=> !err);
  p_phys_range_r7: assert property (@(posedge clk) disable iff (rst)
    mode32 |-> (wr_phys < IDXW'(SLOTS/2) && rd_phys < IDXW'(SLOTS/2)));
endmodule

// File: tb/test_dbt_dest_regfile.sv
`timescale 1ns/1ps
module test_dbt_dest_regfile;
  localparam int SLOTS = 16;
  localparam int DW    = 16;
  localparam int IDXW  = $clog2(SLOTS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode32 = 1'b0;
  logic wr_en = 1'b0, math_commit = 1'b0, rd_en = 1'b0, drain_release = 1'b0;
  logic [IDXW-1:0] wr_idx = '0, rd_idx = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid, math_half, drain_owns, drain_half, busy, err;

  always #10 clk = ~clk;

  dbt_dest_regfile #(.SLOTS(SLOTS), .DW(DW)) i_dbt_dest_regfile (
    .clk(clk), .rst(rst), .mode32(mode32), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .math_commit(math_commit), .rd_en(rd_en), .rd_idx(rd_idx),
    .drain_release(drain_release), .rd_data(rd_data), .rd_valid(rd_valid),
    .math_half(math_half), .drain_owns(drain_owns), .drain_half(drain_half),
    .busy(busy), .err(err)
  );

  int vectors = 0;
  int fails   = 0;
  bit finished = 0;

  logic [DW-1:0] model [SLOTS];
  logic m_mh, m_pv, m_ph, m_pend, m_err, m_rv;
  logic [DW-1:0] m_rd;

  function automatic int phys(input logic h, input int idx, input logic m32);
    int t = m32 ? SLOTS/2 : SLOTS;
    return ((h ? t/2 : 0) + idx) % t;
  endfunction

  function automatic int half_size(input logic m32);
    return m32 ? SLOTS/4 : SLOTS/2;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < SLOTS; i++) model[i] = '0;
    m_mh = 0; m_pv = 0; m_ph = 1; m_pend = 0; m_err = 0; m_rv = 0; m_rd = '0;
  endtask

  task automatic do_reset(input logic m32);
    rst = 1; mode32 = m32;
    wr_en = 0; rd_en = 0; math_commit = 0; drain_release = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
    vectors++;
    chk("R1 math_half", {15'd0, math_half}, 16'd0);
    chk("R1 drain_owns", {15'd0, drain_owns}, 16'd0);
    chk("R1 drain_half", {15'd0, drain_half}, 16'd1);
    chk("R1 busy", {15'd0, busy}, 16'd0);
  endtask

  // Drive inputs (already at negedge), clock once, update model, compare at next negedge.
  task automatic step(input string tag, input logic we, input int wi, input logic [DW-1:0] wd,
                      input logic cm, input logic re, input int ri, input logic rl);
    logic rel_ok, acc;
    int hs;
    wr_en = we; wr_idx = IDXW'(wi); wr_data = wd; math_commit = cm;
    rd_en = re; rd_idx = IDXW'(ri); drain_release = rl;
    @(posedge clk);
    hs = half_size(mode32);
    m_rv = re;
    if (re) m_rd = model[phys(m_ph, ri, mode32)];
    m_err = (we && wi >= hs) || (re && ri >= hs);
    if (we) model[phys(m_mh, wi, mode32)] = wd;
    rel_ok = rl && m_pv;
    acc = (cm || m_pend) && (!m_pv || rel_ok);
    if (acc) begin
      m_ph = m_mh; m_mh = ~m_mh; m_pv = 1; m_pend = 0;
    end else begin
      if (rel_ok) m_pv = 0;
      if (cm) m_pend = 1;
    end
    @(negedge clk);
    vectors++;
    chk("R4 math_half", {15'd0, math_half}, {15'd0, m_mh});
    chk("R5 drain_owns", {15'd0, drain_owns}, {15'd0, m_pv});
    chk("R4 drain_half", {15'd0, drain_half}, {15'd0, m_ph});
    chk("R6 busy", {15'd0, busy}, {15'd0, m_pend});
    chk("R8 err", {15'd0, err}, {15'd0, m_err});
    chk("R2 rd_valid", {15'd0, rd_valid}, {15'd0, m_rv});
    if (m_rv) chk(tag, rd_data, m_rd);
  endtask

  task automatic idle();
    step("R2 idle", 0, 0, '0, 0, 0, 0, 0);
  endtask

  task automatic random_run(input int n, input logic m32);
    int hs = half_size(m32);
    for (int k = 0; k < n; k++) begin
      logic we, re, cm, rl;
      int wi, ri;
      we = ($urandom % 2) == 0;
      re = ($urandom % 2) == 0;
      cm = ($urandom % 10) == 0;
      rl = ($urandom % 7) == 0;
      wi = (($urandom % 8) == 0) ? int'($urandom % SLOTS) : int'($urandom % hs);
      ri = (($urandom % 8) == 0) ? int'($urandom % SLOTS) : int'($urandom % hs);
      step(m32 ? "R7 rd_data random" : "R3 rd_data random",
           we, wi, DW'($urandom), cm, re, ri, rl);
    end
  endtask

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0d1b));
    do_reset(0);
    // R1: every slot reads zero (reads on drain half 1 wrap over all 16 slots)
    for (int i = 0; i < SLOTS; i++) step("R1 zero slot", 0, 0, '0, 0, 1, i, 0);
    // R2/R9: write relative 3 of half 0, commit, read back; same-cycle write+read
    step("R2 write", 1, 3, 16'hA5A5, 0, 0, 0, 0);
    step("R4 commit", 0, 0, '0, 1, 0, 0, 0);
    step("R9 write+read", 1, 3, 16'h1234, 0, 1, 3, 0);
    idle();
    // R8: index 8 from half 1 aliases into slot 0 of half 0 (the drain half is 0)
    step("R8 alias write", 1, 8, 16'hBEEF, 0, 1, 0, 0);
    step("R8 alias read", 0, 0, '0, 0, 1, 0, 0);
    // R6: commit while drain owns -> held, busy until release
    step("R6 held commit", 0, 0, '0, 1, 0, 0, 0);
    step("R6 busy hold", 0, 0, '0, 0, 0, 0, 0);
    step("R6 release accepts", 0, 0, '0, 0, 0, 0, 1);
    idle();
    // R5: release, then stray release is ignored
    step("R5 release", 0, 0, '0, 0, 0, 0, 1);
    step("R5 stray release", 0, 0, '0, 0, 0, 0, 1);
    // R9: same physical slot read-before-write (drain half vs alias from math half)
    step("R9 setup commit", 1, 1, 16'h0F0F, 1, 0, 0, 0);
    step("R9 read old", 1, 9, 16'h7777, 0, 1, 1, 0);
    step("R9 read new", 0, 0, '0, 0, 1, 1, 0);
    random_run(3000, 0);

    do_reset(1);
    // R7: 32-bit mode, 8 slots, half size 4; index 4 wraps into the other half
    for (int i = 0; i < SLOTS/2; i++) step("R7 zero slot", 0, 0, '0, 0, 1, i, 0);
    step("R7 write", 1, 4, 16'hC0DE, 0, 0, 0, 0);
    step("R7 read wrapped", 0, 0, '0, 0, 1, 0, 0);
    step("R7 commit", 1, 2, 16'h2222, 1, 0, 0, 0);
    step("R7 read half0", 0, 0, '0, 0, 1, 2, 0);
    random_run(3000, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule